// File: doc/BRIEF.md
# Device Power-State and Wake Controller

This block keeps track of the power state of a network endpoint that sits on a shared host bus, and it raises that endpoint's wake request. Software moves the device between four power levels by writing a 2-bit state field. The full-power level is split in two. The device starts in an uninitialized full-power substate. It moves to the active full-power substate the first time host software programs one of its base address registers.

The controller has five named states:
- `PS_D0U`: full power, base addresses not yet programmed.
- `PS_D0A`: full power, active.
- `PS_D1`: light sleep.
- `PS_D2`: deeper sleep.
- `PS_D3`: deepest sleep, with main power possibly removed.

The transitions are:
- *Program*: `PS_D0U` to `PS_D0A` on a base-address write.
- *Sleep*: from a full-power substate, or from a shallower sleep, to a deeper sleep state on a state-field write.
- *Resume*: `PS_D1` or `PS_D2` back to `PS_D0A`.
- *Cold return*: `PS_D3` back to `PS_D0U`, because the base addresses have to be programmed again.

The block also gates ordinary bus transactions. They pass only at full power. Configuration accesses are outside this gate and are always accepted. In `PS_D1` and `PS_D2`, a matching packet or a change in link status latches a sticky wake status. In `PS_D3` the same events latch the status only while auxiliary power is present. The active-low event output is driven low while the status is set and wake is enabled. It stays low until software clears the status.

Top module: `pm_wake_ctrl`

## Requirements
- R1: While and after `por_n` is low, the controller is in `PS_D0U`: `pstate`=00, `d0_active`=0, `bus_txn_ok`=1, `pme_n`=1 and the wake status is cleared.
- R2: In `PS_D0U`, a pulse on any bit of `bar_wr` moves the controller to `PS_D0A` (`d0_active`=1) on the next clock edge. In every other state `bar_wr` has no effect.
- R3: `pstate` reports 00 in both full-power substates, 01 in `PS_D1`, 10 in `PS_D2` and 11 in `PS_D3`. The same encoding is used for `ps_wr_data`.
- R4: In either full-power substate, a write of 01, 10 or 11 moves the controller to the matching sleep state on the next edge. A write of 00 changes nothing.
- R5: In `PS_D1` or `PS_D2`, a write of 00 resumes to `PS_D0A`, and a write of a deeper state is accepted. A write of the current state or of a shallower sleep state is ignored.
- R6: In `PS_D3`, only a write of 00 is accepted, and it lands in `PS_D0U`. Every other write is ignored.
- R7: `bus_txn_ok` is 1 exactly when the controller is in a full-power substate.
- R8: A wake event (`pkt_match` or `link_chg`) in `PS_D1` or `PS_D2` sets the sticky wake status on the next edge. In either full-power substate, wake events are ignored.
- R9: In `PS_D3`, a wake event sets the wake status only when `aux_pwr` is 1 in the same cycle.
- R10: `pme_n` is 0 exactly when the wake status is set and `wake_en` is 1. A `sts_clr` pulse clears the status on the next edge. A wake event in the same cycle wins over the clear.
- R11: In `PS_D0U`, an accepted state-field write in the same cycle as a `bar_wr` pulse takes precedence, and the controller enters the requested sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| ps_wr_en | input | 1 | Write strobe for the power-state field |
| ps_wr_data | input | 2 | Requested power state (00,01,10,11) |
| bar_wr | input | NUM_BARS | One strobe per base address register written |
| pkt_match | input | 1 | Wake-qualifying packet detected |
| link_chg | input | 1 | Link status changed |
| aux_pwr | input | 1 | Auxiliary power present |
| wake_en | input | 1 | Wake output enable |
| sts_clr | input | 1 | Write-1-to-clear pulse for the wake status |
| pstate | output | 2 | Current power-state field |
| d0_active | output | 1 | 1 in the active full-power substate |
| bus_txn_ok | output | 1 | Non-configuration bus transactions permitted |
| pme_n | output | 1 | Active-low power-management event |

## Verification
A wrong internal state becomes visible at the ports one clock edge after the write or event that caused it. `pstate` and `bus_txn_ok` expose the power level directly. `d0_active` separates the two full-power substates, so a missed base-address promotion, or a cold return that lands in the active substate, shows up on that flag. A wake status that is lost or set wrongly shows on `pme_n` in the next cycle whenever `wake_en` is high. The bench uses a reference model to predict all four outputs every cycle, under random writes, base-address strobes, events and auxiliary-power levels.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

    typedef enum logic [2:0] {
        PS_D0U = 3'd0,
        PS_D0A = 3'd1,
        PS_D1  = 3'd2,
        PS_D2  = 3'd3,
        PS_D3  = 3'd4
    } pm_state_e;

    localparam int unsigned FIELD_W = 2;

    localparam logic [FIELD_W-1:0] FLD_D0 = 2'b00;
    localparam logic [FIELD_W-1:0] FLD_D1 = 2'b01;
    localparam logic [FIELD_W-1:0] FLD_D2 = 2'b10;
    localparam logic [FIELD_W-1:0] FLD_D3 = 2'b11;

    // Sleep state for a nonzero field value; 00 maps to the active substate
    function automatic pm_state_e field_to_state(input logic [FIELD_W-1:0] f);
        pm_state_e s;
        case (f)
            FLD_D1:  s = PS_D1;
            FLD_D2:  s = PS_D2;
            FLD_D3:  s = PS_D3;
            default: s = PS_D0A;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pm_wake_pkg::*;
#(
    parameter int unsigned NUM_BARS = 3
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                ps_wr_en,
    input  logic [FIELD_W-1:0]  ps_wr_data,
    input  logic [NUM_BARS-1:0] bar_wr,
    output pm_state_e           cur_st
);

    pm_state_e nxt_st;
    logic      bar_any;
    logic      sleep_req;

    assign bar_any   = |bar_wr;
    assign sleep_req = ps_wr_en && (ps_wr_data != FLD_D0);

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cur_st <= PS_D0U;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // Transition selection
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            PS_D0U: begin
                if (sleep_req) begin
                    nxt_st = field_to_state(ps_wr_data);
                end else if (bar_any) begin
                    nxt_st = PS_D0A;
                end
            end
            PS_D0A: begin
                if (sleep_req) begin
                    nxt_st = field_to_state(ps_wr_data);
                end
            end
            PS_D1: begin
                if (ps_wr_en) begin
                    case (ps_wr_data)
                        FLD_D0:  nxt_st = PS_D0A;
                        FLD_D2:  nxt_st = PS_D2;
                        FLD_D3:  nxt_st = PS_D3;
                        default: nxt_st = PS_D1;
                    endcase
                end
            end
            PS_D2: begin
                if (ps_wr_en) begin
                    case (ps_wr_data)
                        FLD_D0:  nxt_st = PS_D0A;
                        FLD_D3:  nxt_st = PS_D3;
                        default: nxt_st = PS_D2;
                    endcase
                end
            end
            PS_D3: begin
                if (ps_wr_en && (ps_wr_data == FLD_D0)) begin
                    nxt_st = PS_D0U;
                end
            end
            default: nxt_st = PS_D0U;
        endcase
    end

    // R2
    program_to_active_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cur_st == PS_D0U && bar_any && !sleep_req) |=> (cur_st == PS_D0A));

    // R6
    d3_exit_only_d0_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cur_st == PS_D3 && !(ps_wr_en && ps_wr_data == FLD_D0)) |=> (cur_st == PS_D3));

    // R6
    cold_return_uninit_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cur_st == PS_D3 && ps_wr_en && ps_wr_data == FLD_D0) |=> (cur_st == PS_D0U));

endmodule

// File: rtl/pm_wake_detect.sv
module pm_wake_detect
    import pm_wake_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  pm_state_e cur_st,
    input  logic      pkt_match,
    input  logic      link_chg,
    input  logic      aux_pwr,
    input  logic      sts_clr,
    output logic      wake_sts
);

    logic can_wake;
    logic wake_evt;

    // Which states may raise a wake
    always_comb begin
        unique case (cur_st)
            PS_D1, PS_D2: can_wake = 1'b1;
            PS_D3:        can_wake = aux_pwr;
            default:      can_wake = 1'b0;
        endcase
    end

    assign wake_evt = can_wake && (pkt_match || link_chg);

    // Sticky status, event wins over clear
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wake_sts <= 1'b0;
        end else if (wake_evt) begin
            wake_sts <= 1'b1;
        end else if (sts_clr) begin
            wake_sts <= 1'b0;
        end
    end

    // R8
    no_wake_at_full_power_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((cur_st == PS_D0U || cur_st == PS_D0A) && !wake_sts) |=> !wake_sts);

    // R9
    d3_needs_aux_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cur_st == PS_D3 && !aux_pwr && !wake_sts) |=> !wake_sts);

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wake_sts && !sts_clr) |=> wake_sts);

endmodule

// File: rtl/pm_out_decode.sv
module pm_out_decode
    import pm_wake_pkg::*;
(
    input  pm_state_e          cur_st,
    input  logic               wake_sts,
    input  logic               wake_en,
    output logic [FIELD_W-1:0] pstate,
    output logic               d0_active,
    output logic               bus_txn_ok,
    output logic               pme_n
);

    // Output process
    always_comb begin
        pstate     = FLD_D0;
        d0_active  = 1'b0;
        bus_txn_ok = 1'b0;
        unique case (cur_st)
            PS_D0U: begin
                bus_txn_ok = 1'b1;
            end
            PS_D0A: begin
                d0_active  = 1'b1;
                bus_txn_ok = 1'b1;
            end
            PS_D1:  pstate = FLD_D1;
            PS_D2:  pstate = FLD_D2;
            PS_D3:  pstate = FLD_D3;
            default: begin
                pstate = FLD_D0;
            end
        endcase
        pme_n = !(wake_sts && wake_en);
    end

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int unsigned NUM_BARS = 3
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                ps_wr_en,
    input  logic [1:0]          ps_wr_data,
    input  logic [NUM_BARS-1:0] bar_wr,
    input  logic                pkt_match,
    input  logic                link_chg,
    input  logic                aux_pwr,
    input  logic                wake_en,
    input  logic                sts_clr,
    output logic [1:0]          pstate,
    output logic                d0_active,
    output logic                bus_txn_ok,
    output logic                pme_n
);

    pm_state_e cur_st;
    logic      wake_sts;

    pm_state_fsm #(.NUM_BARS(NUM_BARS)) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .ps_wr_en   (ps_wr_en),
        .ps_wr_data (ps_wr_data),
        .bar_wr     (bar_wr),
        .cur_st     (cur_st)
    );

    pm_wake_detect u_wake (
        .clk       (clk),
        .por_n     (por_n),
        .cur_st    (cur_st),
        .pkt_match (pkt_match),
        .link_chg  (link_chg),
        .aux_pwr   (aux_pwr),
        .sts_clr   (sts_clr),
        .wake_sts  (wake_sts)
    );

    pm_out_decode u_out (
        .cur_st     (cur_st),
        .wake_sts   (wake_sts),
        .wake_en    (wake_en),
        .pstate     (pstate),
        .d0_active  (d0_active),
        .bus_txn_ok (bus_txn_ok),
        .pme_n      (pme_n)
    );

    // R4
    sleep_closes_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_txn_ok && ps_wr_en && ps_wr_data != FLD_D0) |=> !bus_txn_ok);

    // R10
    pme_held_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!pme_n && !sts_clr && wake_en) |=> (!pme_n || !wake_en));

    // R7
    gate_follows_field_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ps_wr_en && ps_wr_data == FLD_D0 && pstate != FLD_D0) |=> bus_txn_ok);

endmodule

// File: tb/pm_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pm_wake_ctrl_tb;

    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          ps_wr_en = 1'b0;
    logic [1:0]    ps_wr_data = 2'b00;
    logic [NB-1:0] bar_wr = '0;
    logic          pkt_match = 1'b0;
    logic          link_chg = 1'b0;
    logic          aux_pwr = 1'b0;
    logic          wake_en = 1'b0;
    logic          sts_clr = 1'b0;
    logic [1:0]    pstate;
    logic          d0_active;
    logic          bus_txn_ok;
    logic          pme_n;

    int checks = 0;
    int fails = 0;

    // model: 0=D0u 1=D0a 2=D1 3=D2 4=D3
    int m_st = 0;
    bit m_sts = 1'b0;

    always #2 clk = ~clk;

    pm_wake_ctrl #(.NUM_BARS(NB)) u_dut (
        .clk(clk), .por_n(por_n), .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data),
        .bar_wr(bar_wr), .pkt_match(pkt_match), .link_chg(link_chg),
        .aux_pwr(aux_pwr), .wake_en(wake_en), .sts_clr(sts_clr),
        .pstate(pstate), .d0_active(d0_active), .bus_txn_ok(bus_txn_ok), .pme_n(pme_n)
    );

    function automatic int depth_of(int st);
        return (st <= 1) ? 0 : st - 1;
    endfunction

    // R4 R5 R6 R11 R2 transition rules
    function automatic int next_state(int st, bit wr, logic [1:0] d, bit bar);
        int dep = depth_of(st);
        int req = int'(d);
        if (wr && ((req == 0 && dep != 0) || (req > dep))) begin
            if (req == 0) return (st == 4) ? 0 : 1;
            return req + 1;
        end
        if (st == 0 && bar) return 1;
        return st;
    endfunction

    // R8 R9 R10 status rules
    function automatic bit next_sts(int st, bit sts, bit ev, bit aux, bit clr);
        bit elig = (st == 2) || (st == 3) || (st == 4 && aux);
        if (elig && ev) return 1'b1;
        if (clr) return 1'b0;
        return sts;
    endfunction

    task automatic chk(string req, string ctx, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, ctx, act, exp, $time);
        end
    endtask

    task automatic check_all(string ctx);
        chk("R3", ctx, int'(pstate), depth_of(m_st));
        chk("R2", ctx, int'(d0_active), (m_st == 1) ? 1 : 0);
        chk("R7", ctx, int'(bus_txn_ok), (m_st <= 1) ? 1 : 0);
        chk("R10", ctx, int'(pme_n), (m_sts && wake_en) ? 0 : 1);
    endtask

    task automatic do_reset();
        por_n = 1'b0;
        ps_wr_en = 1'b0; bar_wr = '0; pkt_match = 1'b0; link_chg = 1'b0; sts_clr = 1'b0;
        repeat (2) @(negedge clk);
        m_st = 0; m_sts = 1'b0;
        chk("R1", "in reset", int'({pstate, d0_active, bus_txn_ok, pme_n}), 5'b00011);
        por_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");
    endtask

    task automatic step(bit wr, logic [1:0] d, logic [NB-1:0] bar, bit pkt, bit lnk,
                        bit aux, bit we, bit clr, string ctx);
        ps_wr_en = wr; ps_wr_data = d; bar_wr = bar; pkt_match = pkt; link_chg = lnk;
        aux_pwr = aux; wake_en = we; sts_clr = clr;
        m_sts = next_sts(m_st, m_sts, pkt | lnk, aux, clr);
        m_st  = next_state(m_st, wr, d, |bar);
        @(posedge clk);
        @(negedge clk);
        check_all(ctx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        @(negedge clk);
        do_reset();
        // directed corner cases
        step(1, 2'b01, 3'b001, 0, 0, 0, 1, 0, "R11 write beats BAR");
        step(1, 2'b01, 3'b000, 0, 0, 0, 1, 0, "R5 same state ignored");
        step(0, 2'b00, 3'b100, 0, 0, 0, 1, 0, "R2 BAR ignored in D1");
        step(0, 2'b00, 3'b000, 1, 0, 0, 1, 0, "R8 packet wake in D1");
        step(0, 2'b00, 3'b000, 0, 0, 0, 1, 1, "R10 clear");
        step(1, 2'b00, 3'b000, 0, 0, 0, 1, 0, "R5 resume to active");
        step(0, 2'b00, 3'b000, 1, 1, 1, 1, 0, "R8 wake ignored in D0");
        step(1, 2'b00, 3'b000, 0, 0, 0, 1, 0, "R4 write 00 in D0");
        step(1, 2'b11, 3'b000, 0, 0, 0, 1, 0, "R4 sleep to D3");
        step(0, 2'b00, 3'b000, 0, 1, 0, 1, 0, "R9 no aux no wake");
        step(1, 2'b01, 3'b000, 0, 0, 1, 1, 0, "R6 D1 write ignored in D3");
        step(0, 2'b00, 3'b000, 0, 1, 1, 1, 0, "R9 aux wake");
        step(0, 2'b00, 3'b000, 0, 0, 1, 0, 0, "R10 wake disabled");
        step(0, 2'b00, 3'b000, 0, 0, 1, 1, 0, "R10 status held");
        step(1, 2'b00, 3'b000, 0, 0, 1, 1, 1, "R6 cold return");
        step(0, 2'b00, 3'b010, 0, 0, 0, 1, 0, "R2 program");
        step(1, 2'b10, 3'b000, 0, 0, 0, 1, 0, "R4 sleep to D2");
        step(1, 2'b01, 3'b000, 0, 0, 0, 1, 0, "R5 shallower ignored");
        step(0, 2'b00, 3'b000, 1, 0, 0, 1, 1, "R10 event beats clear");
        step(0, 2'b00, 3'b000, 0, 0, 0, 1, 0, "R10 still set");
        do_reset();
        // random phase
        for (int i = 0; i < 5000; i++) begin
            if ($urandom_range(0, 599) == 0) begin
                do_reset();
            end else begin
                step(($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)),
                     ($urandom_range(0, 7) == 0) ? NB'($urandom_range(1, (1 << NB) - 1)) : '0,
                     ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
                     1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0),
                     ($urandom_range(0, 9) == 0), "random R2 R4 R5 R6 R8 R9 R10");
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule